// File: doc/BRIEF.md
# Bit-Serial Absolute-Difference Element

This element forms the absolute difference of two unsigned pixels, a candidate pixel and a reference pixel, without a subtractor. Both pixels arrive one bit-plane per clock, most significant bit first. Each clock the element emits one radix-2 signed digit of |c − r|, so a downstream online adder tree can start summing before the low bits of the pixels are known. No carry is propagated. The sign of the difference is found on the fly from the first bit pair that differs. From then on, each bit pair is either passed through or swapped.

A digit is a pair of bits {a, b} whose value is b − a. A start strobe marks the most significant bit of every new pixel pair and clears the per-pixel flags, so pixel pairs can follow one another with no idle cycle between them. A drop count, captured with the start strobe, shortens the pixel to its upper bit-planes for reduced-precision matching. Planes past that point yield zero digits whatever is on the bit inputs.

Top module: `absdiff_bitserial`

## Requirements
- R1: While reset is asserted and after its release, `digitOut` is 2'b00. Until the first `newData` strobe, the output stays 2'b00 whatever the bit inputs carry.
- R2: A digit {digitOut[1], digitOut[0]} has the value digitOut[0] − digitOut[1]. While all bit pairs of the current pixel have been equal so far, the digit is {candBit, refBit}: 2'b00 for two zeros and 2'b11 for two ones.
- R3: The first plane of a pixel on which candBit and refBit differ yields the digit 2'b01, whichever bit is the larger.
- R4: After the first differing plane, a pixel with c < r gives {candBit, refBit} on every later active plane, and a pixel with c > r gives {refBit, candBit}.
- R5: The digit for the bits presented in one cycle appears on `digitOut` after the next rising clock edge.
- R6: `newData` high marks the most significant bit and clears the sign state, so a new pixel may start in the cycle right after the previous pixel's last plane.
- R7: `dropBits` is captured only in the `newData` cycle. Values above 4 count as 4. Only the first 8 − dropBits planes are active, and every later plane yields 2'b00 whatever the bit inputs or a changed `dropBits` carry.
- R8: The digits of one pixel, weighted 2^7 down to 2^0 in arrival order, sum to |(c >> D) − (r >> D)| · 2^D, where D is the effective drop count.
- R9: After the last plane of a pixel, with no new strobe, the output stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| newData | input | 1 | Start of a pixel pair; the bits in this cycle are the most significant |
| dropBits | input | 3 | Number of low bit-planes to skip, sampled with newData |
| candBit | input | 1 | Current bit-plane of the candidate pixel |
| refBit | input | 1 | Current bit-plane of the reference pixel |
| digitOut | output | 2 | Registered signed digit {a, b}, value b − a |

## Verification
The bench aims at the plane where the sign is decided. It uses pairs that differ first at the MSB, first at the LSB, or not at all. A design that latched the sign one plane late, or emitted 10 on that plane, would give weighted sums with the wrong sign or size. Pixels are sent back to back so that stale sign flags would corrupt the second pixel. The reduced-precision runs feed random bits on the skipped planes and change the drop input in the middle of a pixel. They also give a drop value above the limit. A design that counted planes wrongly, did not clamp, or sampled the drop input late would emit nonzero trailing digits or truncate at the wrong plane. A grid sweep over candidate and reference values checks every weighted sum against the absolute difference.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;
  // strobes from the plane sequencer to the digit datapath
  typedef struct packed {
    logic restart;   // first plane of a new pixel pair
    logic active;    // current plane is within the kept precision
  } planeStrobe_t;
endpackage

// File: rtl/absdiff_ctrl.sv
module absdiff_ctrl
  import absdiff_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int MAX_DROP = 4,
  localparam int DROP_W  = $clog2(MAX_DROP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newData,
  input  logic [DROP_W-1:0] dropBits,
  output planeStrobe_t      strobe
);
  localparam int CNT_W = $clog2(PIX_W + 1);

  logic [CNT_W-1:0] planeCnt;
  logic [CNT_W-1:0] planeLimit;
  logic [DROP_W-1:0] dropClamp;
  logic [CNT_W-1:0] limitNow;

  assign dropClamp = (int'(dropBits) > MAX_DROP) ? DROP_W'(MAX_DROP) : dropBits;
  assign limitNow  = CNT_W'(PIX_W) - CNT_W'(dropClamp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      planeCnt   <= CNT_W'(PIX_W);
      planeLimit <= CNT_W'(PIX_W);
    end else if (newData) begin
      planeCnt   <= CNT_W'(1);
      planeLimit <= limitNow;
    end else if (planeCnt < CNT_W'(PIX_W)) begin
      planeCnt <= planeCnt + CNT_W'(1);
    end
  end

  assign strobe.restart = newData;
  assign strobe.active  = newData | (planeCnt < planeLimit);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(planeCnt) <= PIX_W);

  // R7
  limit_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(planeLimit) >= PIX_W - MAX_DROP && int'(planeLimit) <= PIX_W);

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.active && !newData) |=> !strobe.active || $past(newData) || newData);
endmodule

// File: rtl/absdiff_dp.sv
module absdiff_dp
  import absdiff_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  planeStrobe_t strobe,
  input  logic         candBit,
  input  logic         refBit,
  output logic [1:0]   digitOut
);
  logic latchQ, greaterQ;
  logic latchNext, greaterNext;
  logic effLatch, effGreater;
  logic [1:0] digitNext;

  assign effLatch   = latchQ   & ~strobe.restart;
  assign effGreater = greaterQ & ~strobe.restart;

  always_comb begin
    digitNext   = 2'b00;
    latchNext   = latchQ;
    greaterNext = greaterQ;
    if (strobe.active) begin
      latchNext   = effLatch;
      greaterNext = effGreater;
      if (!effLatch) begin
        if (candBit != refBit) begin
          digitNext   = 2'b01;
          latchNext   = 1'b1;
          greaterNext = candBit;
        end else begin
          digitNext = {candBit, refBit};
        end
      end else if (effGreater) begin
        digitNext = {refBit, candBit};
      end else begin
        digitNext = {candBit, refBit};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ   <= 1'b0;
      greaterQ <= 1'b0;
      digitOut <= 2'b00;
    end else begin
      latchQ   <= latchNext;
      greaterQ <= greaterNext;
      digitOut <= digitNext;
    end
  end

  // R4
  greater_needs_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    greaterQ |-> latchQ);

  // R3
  first_diff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && (strobe.restart || !latchQ) && (candBit != refBit))
      |=> digitOut == 2'b01);

  // R2
  equal_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && (strobe.restart || !latchQ) && (candBit == refBit))
      |=> digitOut == {$past(candBit), $past(candBit)});

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !strobe.restart) |=> latchQ);

  // R7
  inactive_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> digitOut == 2'b00);
endmodule

// File: rtl/absdiff_bitserial.sv
module absdiff_bitserial
  import absdiff_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int MAX_DROP = 4,
  localparam int DROP_W  = $clog2(MAX_DROP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              newData,
  input  logic [DROP_W-1:0] dropBits,
  input  logic              candBit,
  input  logic              refBit,
  output logic [1:0]        digitOut
);
  planeStrobe_t strobe;

  absdiff_ctrl #(.PIX_W(PIX_W), .MAX_DROP(MAX_DROP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .newData  (newData),
    .dropBits (dropBits),
    .strobe   (strobe)
  );

  absdiff_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .candBit  (candBit),
    .refBit   (refBit),
    .digitOut (digitOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rstN |=> digitOut == 2'b00);
endmodule

// File: tb/sim_absdiff_bitserial.sv
module sim_absdiff_bitserial;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       newData = 1'b0;
  logic [2:0] dropBits = 3'd0;
  logic       candBit = 1'b0;
  logic       refBit = 1'b0;
  logic [1:0] digitOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  absdiff_bitserial u0 (
    .clk(clk), .rstN(rstN), .newData(newData), .dropBits(dropBits),
    .candBit(candBit), .refBit(refBit), .digitOut(digitOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkVal(string req, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one idle plane: no strobe, random bits; digit must stay 00 (R1/R9)
  task automatic idlePlane(string req);
    newData = 1'b0;
    candBit = 1'($urandom);
    refBit  = 1'($urandom);
    @(negedge clk);
    checkVal(req, int'(digitOut), 0);
  endtask

  // feed one pixel pair; check each digit (R2..R5,R7) and the weighted sum (R8)
  task automatic runPixel(logic [7:0] c, logic [7:0] r, int rb, string req, bit digitChecks);
    int dEff = (rb > 4) ? 4 : rb;
    int planes = 8 - dEff;
    bit lat = 0;
    bit gr = 0;
    int sum = 0;
    int expSum;
    int cs = int'(c) >> dEff;
    int rs = int'(r) >> dEff;
    expSum = ((cs > rs) ? (cs - rs) : (rs - cs)) << dEff;
    for (int k = 0; k < 8; k++) begin
      logic [1:0] expD;
      newData  = (k == 0);
      dropBits = (k == 0) ? 3'(rb) : 3'($urandom);
      if (k < planes) begin
        candBit = c[7-k];
        refBit  = r[7-k];
        if (!lat) begin
          if (candBit != refBit) begin
            expD = 2'b01; lat = 1; gr = candBit;
          end else begin
            expD = {candBit, refBit};
          end
        end else begin
          expD = gr ? {refBit, candBit} : {candBit, refBit};
        end
      end else begin
        candBit = 1'($urandom);
        refBit  = 1'($urandom);
        expD = 2'b00;
      end
      @(negedge clk);
      if (digitChecks) checkVal({req, " digit (R5)"}, int'(digitOut), int'(expD));
      sum += (int'(digitOut[0]) - int'(digitOut[1])) * (1 << (7 - k));
    end
    newData = 1'b0;
    checkVal({req, " weighted sum (R8)"}, sum, expSum);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R1 in reset", int'(digitOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after reset", int'(digitOut), 0);
    repeat (4) idlePlane("R1 idle before first strobe");
  endtask

  task automatic testEqual();
    runPixel(8'h00, 8'h00, 0, "R2 all zero", 1);
    runPixel(8'hFF, 8'hFF, 0, "R2 all one", 1);
    runPixel(8'hA5, 8'hA5, 0, "R2 mixed equal", 1);
  endtask

  task automatic testSign();
    runPixel(8'h80, 8'h7F, 0, "R3 c>r at msb", 1);
    runPixel(8'h7F, 8'h80, 0, "R3 c<r at msb", 1);
    runPixel(8'h00, 8'hFF, 0, "R4 min-max", 1);
    runPixel(8'hFF, 8'h00, 0, "R4 max-min", 1);
    runPixel(8'h54, 8'h55, 0, "R3 diff at lsb", 1);
    runPixel(8'h9C, 8'h93, 0, "R4 swap later planes", 1);
  endtask

  task automatic testBackToBack();
    runPixel(8'hF0, 8'h0F, 0, "R6 first", 1);
    runPixel(8'h0F, 8'hF0, 0, "R6 second sign flips", 1);
    runPixel(8'h33, 8'h33, 0, "R6 third equal", 1);
  endtask

  task automatic testDrop();
    runPixel(8'h3F, 8'h30, 4, "R7 low bits only differ", 1);
    runPixel(8'hC8, 8'h25, 2, "R7 drop two", 1);
    runPixel(8'h1F, 8'hE3, 7, "R7 clamp to four", 1);
    runPixel(8'hFF, 8'h00, 3, "R7 drop three", 1);
    repeat (3) idlePlane("R9 idle after pixel");
  endtask

  task automatic testSweep();
    for (int c = 0; c < 256; c += 5) begin
      for (int r = 0; r < 256; r += 7) begin
        runPixel(8'(c), 8'(r), 0, "R8 sweep", 0);
      end
    end
    for (int c = 3; c < 256; c += 29) begin
      for (int r = 1; r < 256; r += 31) begin
        runPixel(8'(c), 8'(r), (c + r) % 5, "R8 sweep reduced", 0);
      end
    end
  endtask

  initial begin
    testReset();
    testEqual();
    testSign();
    testBackToBack();
    testDrop();
    testSweep();
    idlePlane("R9 final idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule